// File: doc/BRIEF.md
# Reconfigurable Packet Serializer

This block turns pixel packets held in two alternating 20-bit banks into one serial bit stream. A 40-bit one-hot location pointer walks the concatenated banks, and the bit it points at drives the serial line. A 3-bit mode word picks which positions the pointer visits inside each bank. That choice sets both the packet length and the readout format: full packets with header, data and address, zero-suppressed packets without header, data-only image packets of 7 or 5 bits, address-only hit packets, or a fixed synchronization word.

The mode word can change at any moment, but the block only samples it on the clock edge that ends a packet, so no packet is cut short or stretched. After reset the block sends a start-of-frame marker of two sync-word packets before it follows the mode word. An end-of-data level, also sampled at packet boundaries, moves the block into an idle state: it raises a done flag and sends the sync word in every slot, or holds the line low while the gate input is high. A packet-start strobe marks the first bit of each packet, so upstream logic can reload the bank that is not being sent.

Top module: `pkt_serializer`

## Requirements
- R1: While reset is held, and on the first bit after it, `pkt_start_o` is 1, `done_o` is 0 and `ser_o` equals bit 19 of `SYNC_WORD` (default 20'hE2B4D). After reset the first two packets (bank A slot, then bank B slot) each carry all 20 bits of `SYNC_WORD`, most significant bit first, whatever the mode word says.
- R2: Each bank holds header in bits [19:17], pixel data in bits [16:10] and address in bits [9:0]; bits go out from higher to lower bank bit. Packet slots alternate bank A, bank B, A, B, starting with bank A after reset, in every state.
- R3: Mode 3'b001, and the unused codes 3'b110 and 3'b111, send all 20 bank bits.
- R4: Mode 3'b010 sends bank bits [16:0] (17 bits, no header).
- R5: Mode 3'b011 sends bank bits [16:10] (7 bits); mode 3'b100 sends bank bits [16:12] (5 bits).
- R6: Mode 3'b101 sends bank bits [9:0] (10 address bits).
- R7: Mode 3'b000 sends the 20-bit `SYNC_WORD` in every slot instead of bank contents.
- R8: The mode word is sampled only on the clock edge that ends the last bit of a packet; a change at any earlier point of a packet leaves that packet's length and bits unchanged and applies from the next packet.
- R9: `pkt_start_o` is 1 on exactly the first bit of each packet and 0 on every other bit.
- R10: `end_of_data_i` is sampled at the same edges as the mode word. If it is 1, the next packet slots are idle: `done_o` is 1 from their first bit and each sends the full `SYNC_WORD`. When it is 0 at a boundary, the next packet follows the mode word again with `done_o` 0.
- R11: While `done_o` and `gate_i` are both 1, `ser_o` is 0.
- R12: A load strobe copies its bank input into that bank on the next rising edge; loading the bank that is not being sent leaves the current packet's bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Requested readout mode |
| load_a_i | input | 1 | Load strobe for bank A |
| load_b_i | input | 1 | Load strobe for bank B |
| bank_a_i | input | 20 | Packet word for bank A |
| bank_b_i | input | 20 | Packet word for bank B |
| end_of_data_i | input | 1 | High when the frame has no more packets |
| gate_i | input | 1 | Silences the line while done |
| ser_o | output | 1 | Serial output bit |
| pkt_start_o | output | 1 | High on the first bit of each packet |
| done_o | output | 1 | High while in the idle state |

## Verification
The bench aims at mode changes placed early, in the middle and on the very last bit of a packet; a design that sampled the mode word every cycle would truncate or lengthen the packet in flight, and one that sampled it one edge late would shift the new length by a packet. It walks every mode code, including the unused ones, so a wrong skip range shows up as shifted or missing header, data or address bits. It reloads the idle bank while the other is shifting, which catches a bank-select swap, and it enters and leaves the idle state with and without gating, where a design raising done one packet late or leaking bits under the gate would disagree with the expected stream.

// File: rtl/pkt_serializer.sv
module pkt_serializer #(
  parameter int HDR_W   = 3,
  parameter int DATA_W  = 7,
  parameter int ADDR_W  = 10,
  parameter int SHORT_W = 5,
  parameter logic [HDR_W+DATA_W+ADDR_W-1:0] SYNC_WORD = 20'hE2B4D
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [2:0]                       mode_i,
  input  logic                             load_a_i,
  input  logic                             load_b_i,
  input  logic [HDR_W+DATA_W+ADDR_W-1:0]   bank_a_i,
  input  logic [HDR_W+DATA_W+ADDR_W-1:0]   bank_b_i,
  input  logic                             end_of_data_i,
  input  logic                             gate_i,
  output logic                             ser_o,
  output logic                             pkt_start_o,
  output logic                             done_o
);

  localparam int PKT_W = HDR_W + DATA_W + ADDR_W;
  localparam int PTR_W = 2 * PKT_W;
  localparam int PW    = $clog2(PTR_W);

  localparam logic [2:0] MODE_SYNC  = 3'b000;
  localparam logic [2:0] MODE_FULL  = 3'b001;
  localparam logic [2:0] MODE_NOHDR = 3'b010;
  localparam logic [2:0] MODE_DATA  = 3'b011;
  localparam logic [2:0] MODE_SHORT = 3'b100;
  localparam logic [2:0] MODE_ADDR  = 3'b101;

  typedef enum logic [1:0] {PH_SOF, PH_RUN, PH_IDLE} phase_t;

  function automatic logic [PW-1:0] first_k(input logic [2:0] m);
    case (m)
      MODE_NOHDR, MODE_DATA, MODE_SHORT: first_k = PW'(HDR_W);
      MODE_ADDR:                         first_k = PW'(HDR_W + DATA_W);
      default:                           first_k = '0;
    endcase
  endfunction

  function automatic logic [PW-1:0] last_k(input logic [2:0] m);
    case (m)
      MODE_DATA:  last_k = PW'(HDR_W + DATA_W - 1);
      MODE_SHORT: last_k = PW'(HDR_W + SHORT_W - 1);
      default:    last_k = PW'(PKT_W - 1);
    endcase
  endfunction

  logic [PKT_W-1:0] bank_a, bank_b, src_a, src_b;
  logic [PTR_W-1:0] ptr, nxt_ptr, vec;
  logic [2:0]       shadow, nxt_mode, eff, nxt_eff;
  phase_t           phase, nxt_phase;
  logic             in_b, boundary;
  logic [PW-1:0]    base, nxt_base, first_pos, last_pos, nxt_pos;

  always_ff @(posedge clk) begin
    if (load_a_i) bank_a <= bank_a_i;
    if (load_b_i) bank_b <= bank_b_i;
  end

  assign in_b      = |ptr[PTR_W-1:PKT_W];
  assign eff       = (phase == PH_RUN) ? shadow : MODE_SYNC;
  assign base      = in_b ? PW'(PKT_W) : '0;
  assign nxt_base  = in_b ? '0 : PW'(PKT_W);
  assign first_pos = base + first_k(eff);
  assign last_pos  = base + last_k(eff);
  assign boundary  = ptr[last_pos];

  always_comb begin
    nxt_phase = phase;
    nxt_mode  = shadow;
    if (phase != PH_SOF || in_b) begin
      nxt_phase = end_of_data_i ? PH_IDLE : PH_RUN;
      nxt_mode  = mode_i;
    end
  end

  assign nxt_eff = (nxt_phase == PH_RUN) ? nxt_mode : MODE_SYNC;
  assign nxt_pos = nxt_base + first_k(nxt_eff);
  assign nxt_ptr = boundary ? (PTR_W'(1) << nxt_pos) : {ptr[PTR_W-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr         <= PTR_W'(1);
      phase       <= PH_SOF;
      shadow      <= MODE_FULL;
      pkt_start_o <= 1'b1;
    end else begin
      ptr         <= nxt_ptr;
      pkt_start_o <= boundary;
      if (boundary) begin
        phase  <= nxt_phase;
        shadow <= nxt_mode;
      end
    end
  end

  assign src_a = (eff == MODE_SYNC) ? SYNC_WORD : bank_a;
  assign src_b = (eff == MODE_SYNC) ? SYNC_WORD : bank_b;

  for (genvar k = 0; k < PKT_W; k++) begin : g_map
    assign vec[k]         = src_a[PKT_W-1-k];
    assign vec[PKT_W + k] = src_b[PKT_W-1-k];
  end

  assign done_o = (phase == PH_IDLE);
  assign ser_o  = !(done_o && gate_i) && |(ptr & vec);

  AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(ptr)); // R2

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(shadow) && $stable(phase)); // R8

  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start_o |-> ptr[first_pos]); // R9

  AST_DONE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> pkt_start_o); // R10

  AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && gate_i |-> !ser_o); // R11

endmodule

// File: tb/tb_pkt_serializer.sv
module tb_pkt_serializer;
  localparam logic [19:0] SYNC = 20'hE2B4D;

  logic clk = 0, rst_n = 0;
  logic [2:0] mode_i = 3'b001;
  logic load_a_i = 0, load_b_i = 0, end_of_data_i = 0, gate_i = 0;
  logic [19:0] bank_a_i = '0, bank_b_i = '0;
  logic ser_o, pkt_start_o, done_o;

  int n_cmp = 0, n_bad = 0;
  logic [19:0] m_a, m_b;
  bit cur_b = 0;
  logic [2:0] drv_mode = 3'b001;
  logic drv_eod = 0;
  int chg_at = -1;
  bit finished = 0;

  pkt_serializer dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .load_a_i(load_a_i), .load_b_i(load_b_i),
    .bank_a_i(bank_a_i), .bank_b_i(bank_b_i), .end_of_data_i(end_of_data_i),
    .gate_i(gate_i), .ser_o(ser_o), .pkt_start_o(pkt_start_o), .done_o(done_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // m: mode code, 8 = sync slot of start/idle state
  task automatic pkt(input int m, input string req, input bit exp_done, input bit silent,
                     input bit reload, input logic [19:0] rval);
    int first, len, at;
    logic [19:0] src, got, exp;
    bit bad_start;
    case (m)
      0, 8:    begin first = 0;  len = 20; end
      2:       begin first = 3;  len = 17; end
      3:       begin first = 3;  len = 7;  end
      4:       begin first = 3;  len = 5;  end
      5:       begin first = 10; len = 10; end
      default: begin first = 0;  len = 20; end
    endcase
    src = (m == 0 || m == 8) ? SYNC : (cur_b ? m_b : m_a);
    at = (chg_at == -1) ? len / 2 : (chg_at == -2 ? len - 1 : chg_at);
    got = '0; exp = '0; bad_start = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      got = {got[18:0], ser_o};
      exp = {exp[18:0], silent ? 1'b0 : src[19-(first+i)]};
      if (pkt_start_o != (i == 0)) bad_start = 1;
      if (i == 0) chk(done_o == exp_done, {req, " done"}, done_o, exp_done);
      if (i == 0 && reload) begin
        if (cur_b) begin load_a_i = 1; bank_a_i = rval; m_a = rval; end
        else       begin load_b_i = 1; bank_b_i = rval; m_b = rval; end
      end
      if (i == 1) begin load_a_i = 0; load_b_i = 0; end
      if (i == at) begin mode_i = drv_mode; end_of_data_i = drv_eod; end
    end
    chk(got == exp, {req, " bits"}, got, exp);
    chk(!bad_start, "R9 start strobe", bad_start, 0);
    cur_b = !cur_b;
  endtask

  function automatic string req_of(input int m);
    case (m)
      0: return "R7";
      2: return "R4";
      3, 4: return "R5";
      5: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic t_reset;
    m_a = 20'h5A3C1; m_b = 20'hC3F0E;
    @(negedge clk); load_a_i = 1; bank_a_i = m_a; load_b_i = 1; bank_b_i = m_b;
    @(negedge clk); load_a_i = 0; load_b_i = 0;
    chk(ser_o == SYNC[19], "R1 ser in reset", ser_o, SYNC[19]);
    chk(pkt_start_o == 1, "R1 start in reset", pkt_start_o, 1);
    chk(done_o == 0, "R1 done in reset", done_o, 0);
    @(posedge clk); #1 rst_n = 1;
  endtask

  task automatic t_sof;
    drv_mode = 3'b001; drv_eod = 0;
    pkt(8, "R1 sof A", 0, 0, 0, '0);
    pkt(8, "R1 sof B", 0, 0, 0, '0);
  endtask

  task automatic t_modes;
    int seq [11] = '{1, 1, 7, 6, 2, 2, 3, 4, 5, 0, 1};
    logic [19:0] vals [4] = '{20'h8F00D, 20'h13579, 20'hFFFFF, 20'h2468A};
    for (int j = 0; j < 10; j++) begin
      drv_mode = 3'(seq[j+1]);
      pkt(seq[j], req_of(seq[j]), 0, 0, 1, vals[j % 4]);
    end
  endtask

  task automatic t_defer;
    chg_at = 0;  drv_mode = 3'b100;
    pkt(1, "R8 early change", 0, 0, 1, 20'hABCDE);
    chg_at = -2; drv_mode = 3'b101;
    pkt(4, "R8 old len kept", 0, 0, 1, 20'h0F0F0);
    chg_at = -1; drv_mode = 3'b010;
    pkt(5, "R8 last bit change", 0, 0, 1, 20'h7E5A1);
    drv_mode = 3'b001;
    pkt(2, "R8 next", 0, 0, 1, 20'h33CC9);
  endtask

  task automatic t_done;
    drv_eod = 1;
    pkt(1, "R10 before idle", 0, 0, 0, '0);
    pkt(8, "R10 idle sync", 1, 0, 0, '0);
    gate_i = 1;
    pkt(8, "R11 gated", 1, 1, 0, '0);
    gate_i = 0;
    drv_eod = 0;
    pkt(8, "R10 idle end", 1, 0, 1, 20'h96A5C);
    pkt(1, "R10 resume", 0, 0, 1, 20'h1D2E3);
    pkt(1, "R12 reloaded", 0, 0, 0, '0);
  endtask

  initial begin
    t_reset;
    t_sof;
    t_modes;
    t_defer;
    t_done;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule